// File: doc/BRIEF.md
# Calendar Real-Time Clock

This peripheral keeps wall-clock time and date as plain binary counters: seconds, minutes, hours, day of month, month, two-digit year and century. A one-cycle `tick` pulse, normally one per second, advances the time by one second while the clock is enabled. The calendar rolls over at the ends of minutes, hours, days, months and years. Month lengths follow the Gregorian rules, including the century exception to leap years.

Software reaches the block through a word-addressed register bus with separate read and write strobes. The time of day sits in one packed word and the date in another. A control word holds a run-enable bit and a write-unlock bit. Counter writes are honoured only while the unlock bit is set. A counter read returns the live time, and also keeps a copy of it, while the clock runs. While the clock is stopped, the read returns the last copy kept. Two further words, the alarm and the alarm status, are decoded but read as zero and ignore writes.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the time word, the date word and the control word all read as zero, and the running time is all zeros.
- R2: Read data appears on `rdata` with `rd_valid` high in the cycle after `rd_en`. The time word (word address 0) holds seconds in [5:0], minutes in [13:8], hours in [20:16] and day of month in [28:24]. All other bits of the time word read as zero.
- R3: The date word (word address 1) holds month in [3:0], where January is 1, two-digit year in [14:8] and century in [20:16]. All other bits of the date word read as zero. Full year = century*100 + year.
- R4: The control word (word address 4) holds enable in bit 0 and unlock in bit 1. It reads back as written in those two bits, and its upper 30 bits read as zero.
- R5: A write to the time or date word while unlock is 0 is dropped. The running time and that word's held value stay unchanged.
- R6: With unlock set, a write to the time or date word loads every field of that word from the write data in one cycle. Bits outside the word's fields are discarded. The other word's fields keep their values. A tick in the same cycle as the write is dropped.
- R7: Each tick while enabled adds one second. Seconds wrap 59 to 0 into minutes, minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into the day. Ticks while enable is 0 have no effect.
- R8: The day wraps to 1 after the month's last day and carries into the month. April, June, September and November have 30 days. The other months, apart from February, have 31. The month wraps from 12 to 1 into the year.
- R9: February has 29 days when the full year is divisible by 4 and not by 100, or when it is divisible by 400. Otherwise it has 28 days.
- R10: The year wraps from 99 to 0 and carries one into the century.
- R11: While enabled, a counter read returns the live value and stores it as that word's held value. While disabled, a counter read returns the held value.
- R12: Reads of the alarm word (word address 2) and the alarm-status word (word address 5) return zero. Writes to them change neither the running time nor the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse marking one elapsed second |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after a read strobe |

## Verification
The calendar is loaded just short of each boundary and then ticked once. The boundaries covered are a plain second, the minute, hour and day carry, a 30-day and a 31-day month end, February in a common year, a leap year, a century year that is not a leap year and a 400-year leap year, and a year-99 December that carries into the century. Each case isolates one branch of the month-length and leap logic. Write data is padded with ones in the unused bit positions, which shows whether the field masks hold. A snapshot is taken with the clock running, the time is advanced, and the clock is then stopped. Stopped reads therefore separate the held copy from the live time. Locked writes, writes that collide with a tick, and accesses to the alarm words are each followed by reads that would expose any change of state.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int WORD_W = 32;
    localparam int SEC_W  = 6;
    localparam int MNT_W  = 6;
    localparam int HR_W   = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YR_W   = 7;
    localparam int CENT_W = 5;

    // word indices on the register bus
    localparam int IDX_TIME   = 0;
    localparam int IDX_DATE   = 1;
    localparam int IDX_ALARM  = 2;
    localparam int IDX_CTRL   = 4;
    localparam int IDX_ALSTAT = 5;

    localparam logic [WORD_W-1:0] TIME_MASK = 32'h1F1F_3F3F;
    localparam logic [WORD_W-1:0] DATE_MASK = 32'h001F_7F0F;

    typedef struct packed {
        logic [CENT_W-1:0] cent;
        logic [YR_W-1:0]   yr;
        logic [MON_W-1:0]  mon;
        logic [DAY_W-1:0]  day;
        logic [HR_W-1:0]   hr;
        logic [MNT_W-1:0]  mnt;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    function automatic logic [WORD_W-1:0] pack_time(input cal_t c);
        return {3'b000, c.day, 3'b000, c.hr, 2'b00, c.mnt, 2'b00, c.sec};
    endfunction

    function automatic logic [WORD_W-1:0] pack_date(input cal_t c);
        return {11'd0, c.cent, 1'b0, c.yr, 4'd0, c.mon};
    endfunction

    // Since 100 is a multiple of 4, the two-digit year alone decides
    // divisibility by 4; year 00 defers the decision to the century.
    function automatic logic is_leap(input logic [YR_W-1:0] yr,
                                     input logic [CENT_W-1:0] cent);
        if (yr == '0)
            return (cent[1:0] == 2'b00);
        return (yr[1:0] == 2'b00);
    endfunction

    function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] mon,
                                                    input logic leap);
        case (mon)
            4'd2:                      return leap ? DAY_W'(29) : DAY_W'(28);
            4'd4, 4'd6, 4'd9, 4'd11:   return DAY_W'(30);
            default:                   return DAY_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/rtc_roll_stage.sv
module rtc_roll_stage #(
    parameter int W = 6
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] last_i,
    input  logic [W-1:0] first_i,
    input  logic         carry_i,
    output logic [W-1:0] next_o,
    output logic         carry_o
);

    logic at_end;

    always_comb begin
        at_end  = (cur_i >= last_i);
        carry_o = carry_i && at_end;
        if (!carry_i)
            next_o = cur_i;
        else if (at_end)
            next_o = first_i;
        else
            next_o = cur_i + W'(1);
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              ld_time_i,
    input  logic              ld_date_i,
    input  logic [WORD_W-1:0] wdata_i,
    output cal_t              now_o
);

    cal_t now_q;
    cal_t nxt;
    logic c_sec, c_mnt, c_hr, c_day, c_mon, c_yr;
    logic [DAY_W-1:0] last_day;

    assign last_day = month_days(now_q.mon, is_leap(now_q.yr, now_q.cent));

    rtc_roll_stage #(.W(SEC_W)) u_sec (
        .cur_i(now_q.sec), .last_i(SEC_W'(59)), .first_i(SEC_W'(0)),
        .carry_i(step_i), .next_o(nxt.sec), .carry_o(c_sec));

    rtc_roll_stage #(.W(MNT_W)) u_mnt (
        .cur_i(now_q.mnt), .last_i(MNT_W'(59)), .first_i(MNT_W'(0)),
        .carry_i(c_sec), .next_o(nxt.mnt), .carry_o(c_mnt));

    rtc_roll_stage #(.W(HR_W)) u_hr (
        .cur_i(now_q.hr), .last_i(HR_W'(23)), .first_i(HR_W'(0)),
        .carry_i(c_mnt), .next_o(nxt.hr), .carry_o(c_hr));

    rtc_roll_stage #(.W(DAY_W)) u_day (
        .cur_i(now_q.day), .last_i(last_day), .first_i(DAY_W'(1)),
        .carry_i(c_hr), .next_o(nxt.day), .carry_o(c_day));

    rtc_roll_stage #(.W(MON_W)) u_mon (
        .cur_i(now_q.mon), .last_i(MON_W'(12)), .first_i(MON_W'(1)),
        .carry_i(c_day), .next_o(nxt.mon), .carry_o(c_mon));

    rtc_roll_stage #(.W(YR_W)) u_yr (
        .cur_i(now_q.yr), .last_i(YR_W'(99)), .first_i(YR_W'(0)),
        .carry_i(c_mon), .next_o(nxt.yr), .carry_o(c_yr));

    assign nxt.cent = now_q.cent + CENT_W'(c_yr);

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q <= '0;
        end else if (ld_time_i) begin
            now_q.day <= wdata_i[28:24];
            now_q.hr  <= wdata_i[20:16];
            now_q.mnt <= wdata_i[13:8];
            now_q.sec <= wdata_i[5:0];
        end else if (ld_date_i) begin
            now_q.cent <= wdata_i[20:16];
            now_q.yr   <= wdata_i[14:8];
            now_q.mon  <= wdata_i[3:0];
        end else begin
            now_q <= nxt;
        end
    end

    assign now_o = now_q;

    // R7
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !ld_time_i && !ld_date_i && now_q.sec == SEC_W'(59))
        |=> (now_q.sec == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !ld_time_i && !ld_date_i) |=> $stable(now_q));

    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ld_time_i |=> (now_q.sec == $past(wdata_i[5:0]) &&
                       now_q.day == $past(wdata_i[28:24]) &&
                       $stable(now_q.mon)));

    // R10
    cent_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !ld_time_i && !ld_date_i && now_q.yr == YR_W'(99) &&
         now_q.mon == MON_W'(12) && now_q.day == DAY_W'(31) &&
         now_q.hr == HR_W'(23) && now_q.mnt == MNT_W'(59) &&
         now_q.sec == SEC_W'(59))
        |=> (now_q.yr == '0 && now_q.cent == CENT_W'($past(now_q.cent) + 1)));

endmodule

// File: rtl/rtc_reg_if.sv
module rtc_reg_if
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  cal_t              now_i,
    output logic              run_o,
    output logic              ld_time_o,
    output logic              ld_date_o,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_valid
);

    localparam logic [ADDR_W-1:0] A_TIME   = ADDR_W'(IDX_TIME);
    localparam logic [ADDR_W-1:0] A_DATE   = ADDR_W'(IDX_DATE);
    localparam logic [ADDR_W-1:0] A_ALARM  = ADDR_W'(IDX_ALARM);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_ALSTAT = ADDR_W'(IDX_ALSTAT);

    logic              run_q;
    logic              unlock_q;
    logic [WORD_W-1:0] held_time;
    logic [WORD_W-1:0] held_date;

    assign ld_time_o = wr_en && unlock_q && (addr == A_TIME);
    assign ld_date_o = wr_en && unlock_q && (addr == A_DATE);
    assign run_o     = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            unlock_q  <= 1'b0;
            held_time <= '0;
            held_date <= '0;
            rdata     <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (wr_en) begin
                if (addr == A_CTRL) begin
                    run_q    <= wdata[0];
                    unlock_q <= wdata[1];
                end
                if (ld_time_o) held_time <= wdata & TIME_MASK;
                if (ld_date_o) held_date <= wdata & DATE_MASK;
            end
            if (rd_en) begin
                case (addr)
                    A_TIME: begin
                        if (run_q) begin
                            held_time <= pack_time(now_i);
                            rdata     <= pack_time(now_i);
                        end else begin
                            rdata <= held_time;
                        end
                    end
                    A_DATE: begin
                        if (run_q) begin
                            held_date <= pack_date(now_i);
                            rdata     <= pack_date(now_i);
                        end else begin
                            rdata <= held_date;
                        end
                    end
                    A_CTRL:  rdata <= {{(WORD_W-2){1'b0}}, unlock_q, run_q};
                    default: rdata <= '0;
                endcase
            end
        end
    end

    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R12
    alarm_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == A_ALARM || addr == A_ALSTAT)) |=> (rdata == '0));

    // R4
    ctrl_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_CTRL) |=> (rdata[WORD_W-1:2] == '0));

    // R5
    locked_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !unlock_q && !rd_en && (addr == A_TIME || addr == A_DATE))
        |=> ($stable(held_time) && $stable(held_date)));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rd_valid
);

    cal_t now;
    logic run;
    logic ld_time;
    logic ld_date;

    rtc_reg_if #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .now_i(now), .run_o(run), .ld_time_o(ld_time),
        .ld_date_o(ld_date), .rdata(rdata), .rd_valid(rd_valid));

    rtc_time_core u_core (
        .clk(clk), .rst(rst), .step_i(tick && run), .ld_time_i(ld_time),
        .ld_date_i(ld_date), .wdata_i(wdata), .now_o(now));

endmodule

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;

    localparam logic [2:0] W_TIME = 3'd0, W_DATE = 3'd1, W_ALARM = 3'd2,
                           W_CTRL = 3'd4, W_ALSTAT = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    rtc_calendar u_rtc_calendar (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid));

    function automatic logic [31:0] pk_t(int d, int h, int m, int s);
        return (32'(d) << 24) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] pk_d(int c, int y, int mo);
        return (32'(c) << 16) | (32'(y) << 8) | 32'(mo);
    endfunction

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_wr_tick(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; tick = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.tag = tag; it.exp = e;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_cal(input int c, input int y, input int mo,
                           input int d, input int h, input int m, input int s);
        bus_wr(W_DATE, pk_d(c, y, mo));
        bus_wr(W_TIME, pk_t(d, h, m, s));
    endtask

    // monitor: pop and compare as results come out
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb.size() == 0) begin
                mismatched++;
                $display("FAIL unexpected read data: actual %08h expected none", rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                compared++;
                if (rdata !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: actual %08h expected %08h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(W_TIME, 32'h0, "R1 time after reset");
        bus_rd(W_DATE, 32'h0, "R1 date after reset");
        bus_rd(W_CTRL, 32'h0, "R1 control after reset");

        // R5 locked writes dropped
        bus_wr(W_TIME, pk_t(5, 5, 5, 5));
        bus_wr(W_DATE, pk_d(20, 5, 5));
        bus_wr(W_CTRL, 32'h1);
        bus_rd(W_TIME, 32'h0, "R5 locked time write");
        bus_rd(W_DATE, 32'h0, "R5 locked date write");

        // R4 control bits
        bus_wr(W_CTRL, 32'hFFFF_FFFF);
        bus_rd(W_CTRL, 32'h3, "R4 control readback");

        // R2 R3 R6 field layout and masking
        bus_wr(W_TIME, pk_t(15, 10, 20, 30) | 32'hE0C0_C0C0);
        bus_rd(W_TIME, pk_t(15, 10, 20, 30), "R2 R6 time word layout");
        bus_wr(W_DATE, pk_d(20, 24, 2) | 32'hFFE0_8070);
        bus_rd(W_DATE, pk_d(20, 24, 2), "R3 R6 date word layout");
        bus_rd(W_TIME, pk_t(15, 10, 20, 30), "R6 time kept across date write");

        // R7 carries
        ticks(1);
        bus_rd(W_TIME, pk_t(15, 10, 20, 31), "R7 one second");
        set_cal(20, 24, 3, 15, 23, 59, 59);
        ticks(1);
        bus_rd(W_TIME, pk_t(16, 0, 0, 0), "R7 day carry");
        set_cal(20, 24, 3, 15, 9, 59, 59);
        ticks(1);
        bus_rd(W_TIME, pk_t(15, 10, 0, 0), "R7 hour carry");

        // R8 month lengths
        set_cal(20, 24, 4, 30, 23, 59, 59);
        ticks(1);
        bus_rd(W_DATE, pk_d(20, 24, 5), "R8 April end");
        bus_rd(W_TIME, pk_t(1, 0, 0, 0), "R8 day back to 1");
        set_cal(20, 23, 1, 30, 23, 59, 59);
        ticks(1);
        bus_rd(W_DATE, pk_d(20, 23, 1), "R8 January 31 exists");
        ticks(86400 - 86400 + 0);
        set_cal(20, 23, 1, 31, 23, 59, 59);
        ticks(1);
        bus_rd(W_DATE, pk_d(20, 23, 2), "R8 January end");

        // R9 February
        set_cal(20, 24, 2, 28, 23, 59, 59);
        ticks(1);
        bus_rd(W_DATE, pk_d(20, 24, 2), "R9 leap 2024 Feb 29");
        set_cal(20, 24, 2, 29, 23, 59, 59);
        ticks(1);
        bus_rd(W_DATE, pk_d(20, 24, 3), "R9 leap 2024 Feb end");
        set_cal(20, 23, 2, 28, 23, 59, 59);
        ticks(1);
        bus_rd(W_DATE, pk_d(20, 23, 3), "R9 common 2023");
        set_cal(21, 0, 2, 28, 23, 59, 59);
        ticks(1);
        bus_rd(W_DATE, pk_d(21, 0, 3), "R9 century 2100 not leap");
        set_cal(20, 0, 2, 28, 23, 59, 59);
        ticks(1);
        bus_rd(W_DATE, pk_d(20, 0, 2), "R9 year 2000 leap");

        // R10 century carry
        set_cal(20, 99, 12, 31, 23, 59, 59);
        ticks(1);
        bus_rd(W_DATE, pk_d(21, 0, 1), "R10 year 2099 to 2100");
        bus_rd(W_TIME, pk_t(1, 0, 0, 0), "R10 time at new century");

        // R6 load beats tick
        set_cal(20, 25, 6, 10, 8, 0, 0);
        bus_wr_tick(W_TIME, pk_t(1, 2, 3, 4));
        bus_rd(W_TIME, pk_t(1, 2, 3, 4), "R6 write wins over tick");
        bus_rd(W_DATE, pk_d(20, 25, 6), "R6 date kept on time write");

        // R11 snapshot, R7 ticks ignored while stopped
        set_cal(20, 24, 5, 10, 8, 0, 0);
        bus_rd(W_TIME, pk_t(10, 8, 0, 0), "R11 live read takes snapshot");
        ticks(3);
        bus_wr(W_CTRL, 32'h2);
        bus_rd(W_TIME, pk_t(10, 8, 0, 0), "R11 stopped read returns snapshot");
        bus_rd(W_CTRL, 32'h2, "R4 unlock only");
        ticks(2);
        bus_wr(W_CTRL, 32'h3);
        bus_rd(W_TIME, pk_t(10, 8, 0, 3), "R7 R11 stopped ticks ignored");

        // R12 alarm words
        bus_wr(W_ALARM, 32'hFFFF_FFFF);
        bus_wr(W_ALSTAT, 32'hFFFF_FFFF);
        bus_rd(W_ALARM, 32'h0, "R12 alarm reads zero");
        bus_rd(W_ALSTAT, 32'h0, "R12 alarm status reads zero");
        bus_rd(W_CTRL, 32'h3, "R12 control untouched");
        bus_rd(W_TIME, pk_t(10, 8, 0, 3), "R12 time untouched");
        bus_rd(W_DATE, pk_d(20, 24, 5), "R12 date untouched");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            mismatched++;
            $display("FAIL R2 missing read results: actual %0d pending expected 0", sb.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule